// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides two 32-bit integers, signed or unsigned, and returns the quotient and the remainder together. It sits in a single execute stage and holds it for a number of cycles that depends on the data. A one-cycle start strobe captures both operands and the mode. The block then works one quotient bit per cycle with restoring shift-subtract. It begins at the most significant set bit of the dividend magnitude, which a leading-zero count finds, so small dividends finish early.

Two cycles of fixed cost frame the iterations. In the first, the block takes absolute values, counts leading zeros and aligns the dividend. In the last, it applies the result signs. Results appear with a one-cycle done strobe and hold until the next result. A zero divisor skips the iterations and raises a flag next to a defined result. Stall control in the surrounding pipeline belongs to the user.

Top module: `vlat_divider`

## Requirements
- R1: A start is accepted on a rising clock edge where `start_i` is high and `busy_o` is low. `busy_o` is high from the next cycle on. Holding `start_i` high launches a new operation in each cycle in which `done_o` is high.
- R2: `busy_o` stays high for exactly W+2 consecutive cycles. W is 32 minus the leading-zero count of the dividend magnitude, so the worst case is 34. `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again.
- R3: In unsigned mode (`signed_i` = 0 at start), `quot_o` is the floor of dividend/divisor and `rem_o` is dividend minus quot_o times divisor.
- R4: In signed mode (`signed_i` = 1, two's complement), the quotient truncates toward zero, so its sign is the XOR of the operand signs. The remainder takes the dividend's sign. The most negative value divided by -1 gives quotient 0x80000000 and remainder 0.
- R5: A zero dividend with a non-zero divisor gives W = 0. `busy_o` is high for 2 cycles and both results are 0.
- R6: A zero divisor keeps `busy_o` high for 2 cycles. It returns an all-ones quotient and the unchanged dividend as the remainder, with `dz_o` high. `dz_o` is low after any operation with a non-zero divisor.
- R7: A start strobe while `busy_o` is high is ignored. The running operation keeps its timing and its results, and no extra done follows.
- R8: `quot_o`, `rem_o` and `dz_o` change only in a cycle where `done_o` is high. Between results they hold, whatever the operand inputs do.
- R9: After reset, `busy_o`, `done_o`, `dz_o`, `quot_o` and `rem_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| start_i | input | 1 | Launch strobe, sampled while idle |
| signed_i | input | 1 | 1 selects two's-complement division, sampled with start |
| dividend_i | input | 32 | Dividend, sampled with start |
| divisor_i | input | 32 | Divisor, sampled with start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle strobe: results valid and newly updated |
| quot_o | output | 32 | Quotient, held until the next done |
| rem_o | output | 32 | Remainder, held until the next done |
| dz_o | output | 1 | Last result came from a zero divisor |

## Verification
The assertions assume nothing about operand values: any dividend, divisor and mode can arrive with a start. They do assume that inputs settle before each rising edge. The bench meets this by driving every input on the falling edge. For the same reason it drives start strobes while busy, operands that move without a start, and a start held high across consecutive operations. None of these breaks an assertion, and each one exercises the ignore and hold rules.

// File: rtl/vlat_div_pkg.sv
package vlat_div_pkg;

  // Sequencer phases: idle, operand preparation, one bit per cycle, sign fix-up.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_ITER = 2'd2,
    ST_FIX  = 2'd3
  } div_state_e;

endpackage

// File: rtl/vlat_div_rstsync.sv
module vlat_div_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sn = chain_q[STAGES-1];

endmodule

// File: rtl/vlat_div_lzc.sv
module vlat_div_lzc #(
  parameter  int WIDTH = 32,
  localparam int CW    = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [CW-1:0]    zeros_o
);

  // Highest set bit wins; an all-zero input reports WIDTH.
  always_comb begin
    zeros_o = CW'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (val_i[i]) begin
        zeros_o = CW'(WIDTH - 1 - i);
      end
    end
  end

endmodule

// File: rtl/vlat_div_step.sv
module vlat_div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] part_i,
  input  logic             bit_i,
  input  logic [WIDTH-1:0] dsr_i,
  output logic [WIDTH-1:0] part_o,
  output logic             qbit_o
);

  logic [WIDTH:0] trial;
  logic [WIDTH:0] diff;

  // One restoring step: shift the next dividend bit in and subtract if it fits.
  always_comb begin
    trial  = {part_i, bit_i};
    diff   = trial - {1'b0, dsr_i};
    qbit_o = (trial >= {1'b0, dsr_i});
    part_o = qbit_o ? diff[WIDTH-1:0] : trial[WIDTH-1:0];
  end

endmodule

// File: rtl/vlat_divider.sv
module vlat_divider #(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] quot_o,
  output logic [WIDTH-1:0] rem_o,
  output logic             dz_o
);

  import vlat_div_pkg::*;

  localparam int CW = $clog2(WIDTH + 1);

  logic rst_sn;

  vlat_div_rstsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // State
  div_state_e       st_q, st_d;
  logic             sgn_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic [WIDTH-1:0] dvd_q, dvd_d;
  logic [WIDTH-1:0] dsr_q, dsr_d;
  logic [WIDTH-1:0] part_q, part_d;
  logic [WIDTH-1:0] quo_q, quo_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             negq_q, negq_d;
  logic             negr_q, negr_d;
  logic             dz_q, dz_d;
  logic             done_q;
  logic [WIDTH-1:0] qout_q, qout_d;
  logic [WIDTH-1:0] rout_q, rout_d;
  logic             dzout_q;

  // Enables
  logic op_en, prep_en, iter_en, res_en;

  // Preparation datapath
  logic [WIDTH-1:0] mag_a, mag_b;
  logic [CW-1:0]    lead_z;
  logic [CW-1:0]    sig_w;

  always_comb begin
    mag_a = (sgn_q && a_q[WIDTH-1]) ? (~a_q + 1'b1) : a_q;
    mag_b = (sgn_q && b_q[WIDTH-1]) ? (~b_q + 1'b1) : b_q;
    sig_w = CW'(WIDTH) - lead_z;
  end

  vlat_div_lzc #(.WIDTH(WIDTH)) u_lzc (
    .val_i   (mag_a),
    .zeros_o (lead_z)
  );

  // Iteration datapath
  logic [WIDTH-1:0] step_part;
  logic             step_qbit;

  vlat_div_step #(.WIDTH(WIDTH)) u_step (
    .part_i (part_q),
    .bit_i  (dvd_q[WIDTH-1]),
    .dsr_i  (dsr_q),
    .part_o (step_part),
    .qbit_o (step_qbit)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    op_en   = 1'b0;
    prep_en = 1'b0;
    iter_en = 1'b0;
    res_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          op_en = 1'b1;
          st_d  = ST_PREP;
        end
      end
      ST_PREP: begin
        prep_en = 1'b1;
        if (b_q == '0 || sig_w == '0) begin
          st_d = ST_FIX;
        end else begin
          st_d = ST_ITER;
        end
      end
      ST_ITER: begin
        iter_en = 1'b1;
        if (cnt_q == CW'(1)) begin
          st_d = ST_FIX;
        end
      end
      ST_FIX: begin
        res_en = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    dvd_d  = dvd_q;
    dsr_d  = dsr_q;
    part_d = part_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    negq_d = negq_q;
    negr_d = negr_q;
    dz_d   = dz_q;
    if (prep_en) begin
      dvd_d  = mag_a << lead_z;
      dsr_d  = mag_b;
      part_d = '0;
      quo_d  = '0;
      cnt_d  = sig_w;
      negq_d = sgn_q & (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
      negr_d = sgn_q & a_q[WIDTH-1];
      dz_d   = (b_q == '0);
    end else if (iter_en) begin
      dvd_d  = dvd_q << 1;
      part_d = step_part;
      quo_d  = {quo_q[WIDTH-2:0], step_qbit};
      cnt_d  = cnt_q - CW'(1);
    end
  end

  always_comb begin
    if (dz_q) begin
      qout_d = '1;
      rout_d = a_q;
    end else begin
      qout_d = negq_q ? (~quo_q + 1'b1) : quo_q;
      rout_d = negr_q ? (~part_q + 1'b1) : part_q;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sgn_q <= 1'b0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (op_en) begin
      sgn_q <= signed_i;
      a_q   <= dividend_i;
      b_q   <= divisor_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dvd_q  <= '0;
      dsr_q  <= '0;
      part_q <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      dz_q   <= 1'b0;
    end else if (prep_en || iter_en) begin
      dvd_q  <= dvd_d;
      dsr_q  <= dsr_d;
      part_q <= part_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      negq_q <= negq_d;
      negr_q <= negr_d;
      dz_q   <= dz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      done_q <= 1'b0;
    end else begin
      done_q <= res_en;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      qout_q  <= '0;
      rout_q  <= '0;
      dzout_q <= 1'b0;
    end else if (res_en) begin
      qout_q  <= qout_d;
      rout_q  <= rout_d;
      dzout_q <= dz_q;
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign quot_o = qout_q;
  assign rem_o  = rout_q;
  assign dz_o   = dzout_q;

  // Assertions
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(busy_o) |-> $past(start_i)); // R1

  AST_ITER_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_ITER && cnt_q > CW'(1)) |=> (st_q == ST_ITER && cnt_q == $past(cnt_q) - CW'(1))); // R2

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |=> !done_o); // R2

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> !busy_o); // R2

  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == ST_FIX && !dz_q) |-> (part_q < dsr_q)); // R3

  AST_DZ_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && dz_o) |-> (quot_o == '1)); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(dz_o))); // R8

endmodule

// File: tb/vlat_divider_tb.sv
module vlat_divider_tb;

  localparam int CLK_P = 10;
  localparam int W     = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         sgn;
  logic [W-1:0] a_in, b_in;
  logic         busy, done, dz;
  logic [W-1:0] quot, rem;

  vlat_divider u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .signed_i   (sgn),
    .dividend_i (a_in),
    .divisor_i  (b_in),
    .busy_o     (busy),
    .done_o     (done),
    .quot_o     (quot),
    .rem_o      (rem),
    .dz_o       (dz)
  );

  always #(CLK_P / 2) clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R9";
  bit    chk_en = 1'b0;

  // Behavioural reference
  int         m_left;
  bit         m_done;
  logic [W-1:0] m_q, m_r, p_q, p_r;
  bit         m_dz, p_dz;

  function automatic int sig_bits(logic [W-1:0] v);
    int n = 0;
    while (v != '0) begin
      n++;
      v = v >> 1;
    end
    return n;
  endfunction

  task automatic model_load(input bit sg, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] mag;
    longint x, y, qq, rr;
    mag = (sg && a[W-1]) ? -a : a;
    if (b == '0) begin
      p_q = '1; p_r = a; p_dz = 1'b1;
      m_left = 2;
    end else begin
      p_dz = 1'b0;
      if (sg) begin
        x = longint'($signed(a));
        y = longint'($signed(b));
      end else begin
        x = longint'({32'd0, a});
        y = longint'({32'd0, b});
      end
      qq = x / y;
      rr = x % y;
      p_q = qq[W-1:0];
      p_r = rr[W-1:0];
      m_left = sig_bits(mag) + 2;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_done = 1'b0;
      m_q = '0; m_r = '0; m_dz = 1'b0;
    end else if (m_left > 0) begin
      m_left--;
      if (m_left == 0) begin
        m_done = 1'b1;
        m_q = p_q; m_r = p_r; m_dz = p_dz;
      end else begin
        m_done = 1'b0;
      end
    end else begin
      m_done = 1'b0;
      if (start) model_load(sgn, a_in, b_in);
    end
  end

  task automatic check(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      check("busy", W'(busy), W'(m_left > 0));
      check("done", W'(done), W'(m_done));
      check("quot", quot, m_q);
      check("rem",  rem,  m_r);
      check("dz",   W'(dz), W'(m_dz));
    end
  end

  task automatic wait_idle();
    int guard = 0;
    while ((m_left > 0 || busy) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    if (guard >= 100) begin
      n_bad++;
      $display("FAIL %s stuck busy: actual %0d expected 0", cur_req, m_left);
    end
    @(negedge clk);
  endtask

  task automatic do_op(input bit sg, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    start = 1'b1; sgn = sg; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0;
    a_in = $urandom; b_in = $urandom; sgn = $urandom;
    wait_idle();
  endtask

  function automatic logic [W-1:0] rnd_val();
    logic [W-1:0] v = $urandom;
    return v >> ($urandom % W);
  endfunction

  initial begin
    #(CLK_P * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; sgn = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    cur_req = "R9";
    check("busy", W'(busy), '0);
    check("done", W'(done), '0);
    check("quot", quot, '0);
    check("rem",  rem,  '0);
    check("dz",   W'(dz), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_en = 1'b1;
    repeat (2) @(negedge clk);

    // R3: unsigned
    cur_req = "R3";
    do_op(1'b0, 32'd100, 32'd7);
    do_op(1'b0, 32'd5, 32'd9);
    do_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op(1'b0, 32'hDEAD_BEEF, 32'd3);
    for (int i = 0; i < 60; i++) do_op(1'b0, rnd_val(), rnd_val() | 32'd1);

    // R2: latency by significant width, including the 34-cycle worst case
    cur_req = "R2";
    do_op(1'b0, 32'hFFFF_FFFF, 32'd1);
    do_op(1'b0, 32'h8000_0000, 32'd2);
    do_op(1'b0, 32'd1, 32'd1);
    do_op(1'b0, 32'h0000_FFFF, 32'd10);
    do_op(1'b1, 32'h8000_0000, 32'd3);

    // R4: signed
    cur_req = "R4";
    do_op(1'b1, -32'sd7, 32'sd2);
    do_op(1'b1, 32'sd7, -32'sd2);
    do_op(1'b1, -32'sd7, -32'sd2);
    do_op(1'b1, 32'h8000_0000, 32'hFFFF_FFFF);
    do_op(1'b1, 32'h8000_0000, 32'd1);
    for (int i = 0; i < 60; i++) do_op(1'b1, $urandom, rnd_val() | 32'd1);

    // R5: zero dividend
    cur_req = "R5";
    do_op(1'b0, 32'd0, 32'd13);
    do_op(1'b1, 32'd0, -32'sd13);

    // R6: zero divisor, then a normal divide clears the flag
    cur_req = "R6";
    do_op(1'b0, 32'd1234, 32'd0);
    do_op(1'b1, -32'sd5, 32'd0);
    do_op(1'b0, 32'd0, 32'd0);
    do_op(1'b0, 32'd50, 32'd6);

    // R7: starts while busy, at several points of a running divide
    cur_req = "R7";
    for (int k = 1; k < 8; k++) begin
      @(negedge clk);
      start = 1'b1; sgn = 1'b0; a_in = 32'h00F0_0000; b_in = 32'd7;
      @(negedge clk);
      start = 1'b0;
      repeat (k * 3) @(negedge clk);
      start = 1'b1; a_in = 32'd9; b_in = 32'd0; sgn = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
    end

    // R1: start held high launches back-to-back operations
    cur_req = "R1";
    @(negedge clk);
    start = 1'b1; sgn = 1'b0; a_in = 32'd15; b_in = 32'd4;
    repeat (25) @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R8: operand inputs move without a start; results must hold
    cur_req = "R8";
    do_op(1'b0, 32'd77, 32'd5);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      a_in = $urandom; b_in = $urandom; sgn = $urandom;
    end
    do_op(1'b1, -32'sd1000, 32'sd33);

    chk_en = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule